// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block produces the serial clock of an I2C controller from a fast input clock. A programmable prescaler first divides the input clock into a slower module clock, marked by a one-cycle tick. Two counters then time the low and the high phase of the serial clock in module-clock ticks. Each phase lasts its programmed count plus a fixed overhead. That overhead is 7 ticks with no prescaling, 6 with a divide-by-two, and 5 for any larger prescale.

Software programs the three divider values through a small write port while the generator is held in reset. It then sets the run bit. The generator toggles the clock only while it runs and the controller reports an active transfer. Otherwise the line stays released high. Single-cycle strobes mark each rising and falling edge of the serial clock, so that the data path can align its own sampling and driving.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset `scl` is 1, `scl_rise`, `scl_fall` and `mod_tick` are 0, the run bit is 0 and all three divider values are 0.
- R2: While running and active, `mod_tick` pulses for one input cycle out of every prescale+1 cycles. Otherwise it stays 0.
- R3: Once enabled, the clock starts with a high phase. The high phase lasts (high count + d) module ticks and the low phase lasts (low count + d) module ticks, so a phase spans (count + d)·(prescale+1) input cycles.
- R4: The overhead d is 7 when the prescale value is 0, 6 when it is 1, and 5 when it is 2 or more.
- R5: `scl_rise` is 1 for exactly the one input cycle in which `scl` first reads 1 after reading 0. `scl_fall` is 1 for exactly the cycle in which `scl` first reads 0 after reading 1. The two strobes are never high together.
- R6: While the run bit is 0 or `active` is 0, `scl` is held at 1, no ticks occur, and both counters restart from zero.
- R7: Writes to the prescale, low or high register have no effect while the run bit is 1.
- R8: Write address map: 0 sets the prescale value, 1 the low count, 2 the high count, and 3 the control register, whose bit 0 is the run bit.
- R9: If the generator leaves its running state during a low phase, `scl` returns to 1 in the next cycle and `scl_rise` pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | A transfer is in progress |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| scl | output | 1 | Serial clock level |
| mod_tick | output | 1 | Module-clock tick |
| scl_rise | output | 1 | Rising-edge strobe |
| scl_fall | output | 1 | Falling-edge strobe |

## Verification
The assertions assume that `active` and the write port change only between clock edges. They also assume that `scl` changes only at a module tick or when the generator stops. The stimulus drives every input on the falling clock edge. It programs the divider registers with the run bit cleared, except for the deliberate write during running that tests R7. It also drops `active` both in the middle of a low phase and while the clock is stopped.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         scl,
  output logic         mod_tick,
  output logic         scl_rise,
  output logic         scl_fall
);
  localparam int CW = W + 1;

  logic [W-1:0]  presc_q, low_q, high_q, pc_q;
  logic [CW-1:0] ph_q, lim;
  logic          run_q, scl_q, rise_q, fall_q;
  logic [3:0]    dly;
  logic          en, last;

  assign en       = run_q & active;
  assign mod_tick = en && (pc_q == presc_q);
  assign dly      = (presc_q == '0) ? 4'd7 : (presc_q == W'(1)) ? 4'd6 : 4'd5;
  assign lim      = {1'b0, (scl_q ? high_q : low_q)} + CW'(dly);
  assign last     = mod_tick && (ph_q == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      low_q   <= '0;
      high_q  <= '0;
      run_q   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == 2'd3) run_q <= wr_data[0];
      else if (!run_q) begin
        case (wr_addr)
          2'd0:    presc_q <= wr_data;
          2'd1:    low_q   <= wr_data;
          default: high_q  <= wr_data;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ph_q   <= '0;
      scl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!en) begin
      pc_q   <= '0;
      ph_q   <= '0;
      scl_q  <= 1'b1;
      rise_q <= ~scl_q;
      fall_q <= 1'b0;
    end else begin
      pc_q   <= mod_tick ? '0 : pc_q + W'(1);
      rise_q <= last & ~scl_q;
      fall_q <= last & scl_q;
      if (last) begin
        ph_q  <= '0;
        scl_q <= ~scl_q;
      end else if (mod_tick) begin
        ph_q  <= ph_q + CW'(1);
      end
    end
  end

  assign scl      = scl_q;
  assign scl_rise = rise_q;
  assign scl_fall = fall_q;
endmodule

module i2c_scl_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic run_q,
  input logic scl,
  input logic mod_tick,
  input logic scl_rise,
  input logic scl_fall
);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall));
  assert_rise_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl && !$past(scl)));
  assert_fall_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl && $past(scl)));
  assert_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> $past(mod_tick));
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && active) |=> scl);
  assert_no_tick_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && active) |-> !mod_tick);
endmodule

bind i2c_scl_gen i2c_scl_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .run_q(run_q), .scl(scl),
  .mod_tick(mod_tick), .scl_rise(scl_rise), .scl_fall(scl_fall)
);

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;
  logic clk = 0, rst_n = 0, active = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic scl, mod_tick, scl_rise, scl_fall;
  int checks = 0, errors = 0, cyc = 0;

  int m_pre = 0, m_lo = 0, m_hi = 0, m_run = 0;
  int m_scl = 1, m_pc = 0, m_ph = 0, m_rise = 0, m_fall = 0;

  always #10 clk = ~clk;

  i2c_scl_gen u_i2c_scl_gen (.clk(clk), .rst_n(rst_n), .active(active), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .scl(scl), .mod_tick(mod_tick),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  function automatic int dval(int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pre = 0; m_lo = 0; m_hi = 0; m_run = 0;
      m_scl = 1; m_pc = 0; m_ph = 0; m_rise = 0; m_fall = 0;
    end else begin
      int tick, lim, oldrun;
      oldrun = m_run;
      if (!(m_run && active)) begin
        m_rise = !m_scl; m_fall = 0; m_scl = 1; m_pc = 0; m_ph = 0;
      end else begin
        tick = (m_pc == m_pre);
        m_pc = tick ? 0 : m_pc + 1;
        m_rise = 0; m_fall = 0;
        if (tick) begin
          lim = (m_scl ? m_hi : m_lo) + dval(m_pre);
          if (m_ph == lim - 1) begin
            m_ph = 0;
            if (m_scl) m_fall = 1; else m_rise = 1;
            m_scl = !m_scl;
          end else m_ph++;
        end
      end
      if (wr_en) begin
        if (wr_addr == 3) m_run = wr_data[0];
        else if (!oldrun) begin
          if (wr_addr == 0) m_pre = wr_data;
          else if (wr_addr == 1) m_lo = wr_data;
          else m_hi = wr_data;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R3 scl", scl, m_scl);
    chk("R2 mod_tick", mod_tick, (m_run && active && m_pc == m_pre) ? 1 : 0);
    chk("R5 scl_rise", scl_rise, m_rise);
    chk("R5 scl_fall", scl_fall, m_fall);
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic phase_len(bit low, output int n);
    do @(negedge clk); while (!(low ? scl_fall : scl_rise));
    n = 1;
    forever begin
      @(negedge clk);
      if (scl != low) n++; else break;
    end
  endtask

  task automatic try_cfg(int p, int lo, int hi, string req);
    int n;
    wr(3, 0);
    wr(0, p); wr(1, lo); wr(2, hi);
    wr(3, 1);
    phase_len(1, n); chk({req, " low phase"}, n, (lo + dval(p)) * (p + 1));
    phase_len(0, n); chk({req, " high phase"}, n, (hi + dval(p)) * (p + 1));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 scl", scl, 1); chk("R1 rise", scl_rise, 0);
    chk("R1 fall", scl_fall, 0); chk("R1 tick", mod_tick, 0);
    rst_n = 1;
    active = 1;
    try_cfg(0, 3, 2, "R4 d7 R8");
    try_cfg(1, 4, 1, "R4 d6");
    try_cfg(3, 2, 6, "R4 d5 R3");
    wr(1, 20);
    phase_len(1, n); chk("R7 low unchanged", n, 28);
    do @(negedge clk); while (!scl_fall);
    repeat (3) @(negedge clk);
    active = 0;
    @(negedge clk);
    chk("R9 scl high", scl, 1); chk("R9 rise", scl_rise, 1);
    repeat (5) begin
      @(negedge clk);
      chk("R6 idle scl", scl, 1); chk("R6 idle tick", mod_tick, 0);
    end
    active = 1;
    wr(3, 0);
    repeat (4) @(negedge clk);
    chk("R6 stopped scl", scl, 1);
    wr(3, 1);
    phase_len(1, n); chk("R3 restart low", n, 28);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule